// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block carries out a load-multiple or store-multiple command. A command supplies a 16-bit register list, a 32-bit base value, the index of the base register, a load/store flag, one of four address modes and a writeback flag. The sequencer then makes one word transfer per cycle over a request/ready memory port. Each transfer presents the register index, the byte address and the direction. On loads, the read word is returned one cycle later together with the register index it belongs to.

The registers are walked from the lowest number to the highest, whatever order software wrote them in. The start address is chosen so that the lowest register always sits at the lowest address. When the last transfer completes, the sequencer pulses `done`. If writeback was requested, it also returns the updated base value. The register file itself is outside the block: store data is fetched by the surrounding logic using the index on `mem_idx`.

Malformed commands are rejected with a single-cycle error pulse and cause no memory traffic. Stack pushes and pops are expressed by choosing the matching address mode.

Top module: `blk_xfer_seq`

## Requirements
- R1: `cmd_ready` is high exactly when the sequencer is idle, including directly after reset. A command is taken only on a cycle with `cmd_valid` and `cmd_ready` both high, and `cmd_valid` while busy has no effect.
- R2: Every register whose bit is set in `cmd_list` is transferred exactly once, in ascending index order, shown on `mem_idx`.
- R3: Successive transfers of one command use addresses that rise by 4.
- R4: `cmd_mode` encoding: 0 increment-after, 1 increment-before, 2 decrement-after, 3 decrement-before. With n listed registers, the first (lowest) address is base, base+4, base-4n+4 and base-4n respectively, all modulo 2^32.
- R5: With `cmd_wb` set, `wb_valid` pulses with `wb_base` equal to base+4n for modes 0 and 1, or base-4n for modes 2 and 3. With `cmd_wb` clear, `wb_valid` stays low.
- R6: A command is illegal if its list is empty, or if `cmd_wb` is set and the list bit at `cmd_base_idx` is set. An illegal command raises `err` for one cycle, in the cycle after acceptance. It makes no transfer and gives no `done` and no `wb_valid`.
- R7: `mem_req` stays high, with `mem_addr`, `mem_idx` and `mem_we` unchanged, until a cycle with `mem_ready` high. Only then does the sequencer move to the next register.
- R8: `mem_we` is 1 for stores and 0 for loads. For a load, `ld_valid` pulses in the cycle after each accepted transfer, with `ld_idx` and `ld_data` set to that transfer's index and its `mem_rdata`. Stores never raise `ld_valid`.
- R9: `done` pulses in the cycle after the last accepted transfer, the sequencer is idle again in that same cycle, and `wb_valid` (when enabled) coincides with `done`.
- R10: Stack forms map onto the modes. Push: full-descending uses mode 3, full-ascending mode 1, empty-descending mode 2, empty-ascending mode 0. Pop: full-descending uses mode 0, full-ascending mode 2, empty-descending mode 1, empty-ascending mode 3. A pop of the same list after a push, both with writeback, restores the original base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_list | input | 16 | Register list, bit i selects register i |
| cmd_base | input | 32 | Base address value |
| cmd_base_idx | input | 4 | Index of the base register |
| cmd_load | input | 1 | 1 load, 0 store |
| cmd_mode | input | 2 | Address mode (see R4) |
| cmd_wb | input | 1 | Request base writeback |
| mem_req | output | 1 | Word transfer request |
| mem_we | output | 1 | Transfer direction, 1 write |
| mem_addr | output | 32 | Byte address of the transfer |
| mem_idx | output | 4 | Register index of the transfer |
| mem_ready | input | 1 | Memory accepts the transfer this cycle |
| mem_rdata | input | 32 | Read word, valid with `mem_ready` on loads |
| ld_valid | output | 1 | Loaded word returned |
| ld_idx | output | 4 | Destination register of the loaded word |
| ld_data | output | 32 | Loaded word |
| done | output | 1 | Command completed |
| wb_valid | output | 1 | Base writeback strobe |
| wb_base | output | 32 | New base value |
| err | output | 1 | Illegal command rejected |

## Verification
The bench runs all four modes as loads and as stores. It uses sparse lists, a full list, a single-register list and a list spanning both ends, so start-address mistakes and ordering mistakes show up as different address/index pairs. A varying ready pattern is applied throughout, which separates a request held through stalls from one that moves ahead early. Empty lists, and base-in-list with and without writeback, distinguish the two illegal cases from the legal one. Push/pop pairs for all four stack forms, checked through their writeback values, confirm the alias mapping, and commands kept valid while busy show they are ignored.

// File: rtl/blk_xfer_seq_pkg.sv
package blk_xfer_seq_pkg;
  typedef enum logic [1:0] {
    AM_INC_AFTER  = 2'd0,
    AM_INC_BEFORE = 2'd1,
    AM_DEC_AFTER  = 2'd2,
    AM_DEC_BEFORE = 2'd3
  } addr_mode_t;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_XFER = 1'b1
  } seq_state_t;
endpackage

// File: rtl/blk_xfer_list_scan.sv
module blk_xfer_list_scan #(
  parameter int NREG = 16,
  localparam int IDXW = $clog2(NREG),
  localparam int CNTW = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] list,
  output logic [CNTW-1:0] cnt,
  output logic [IDXW-1:0] low_idx
);
  always_comb begin
    cnt     = '0;
    low_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      cnt = cnt + CNTW'(list[i]);
      if (list[i]) low_idx = IDXW'(i);
    end
  end
endmodule

// File: rtl/blk_xfer_addr_gen.sv
module blk_xfer_addr_gen
  import blk_xfer_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CNTW = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [AW-1:0]   base,
  input  logic [CNTW-1:0] cnt,
  input  addr_mode_t      mode,
  output logic [AW-1:0]   start_addr,
  output logic [AW-1:0]   final_base
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
  logic [AW-1:0] span;

  always_comb begin
    span = AW'(cnt) * STEP;
    unique case (mode)
      AM_INC_AFTER:  begin start_addr = base;               final_base = base + span; end
      AM_INC_BEFORE: begin start_addr = base + STEP;        final_base = base + span; end
      AM_DEC_AFTER:  begin start_addr = base - span + STEP; final_base = base - span; end
      default:       begin start_addr = base - span;        final_base = base - span; end
    endcase
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_seq_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDXW = $clog2(NREG),
  localparam int CNTW = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [NREG-1:0] cmd_list,
  input  logic [AW-1:0]   cmd_base,
  input  logic [IDXW-1:0] cmd_base_idx,
  input  logic            cmd_load,
  input  logic [1:0]      cmd_mode,
  input  logic            cmd_wb,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [IDXW-1:0] mem_idx,
  input  logic            mem_ready,
  input  logic [DW-1:0]   mem_rdata,
  output logic            ld_valid,
  output logic [IDXW-1:0] ld_idx,
  output logic [DW-1:0]   ld_data,
  output logic            done,
  output logic            wb_valid,
  output logic [AW-1:0]   wb_base,
  output logic            err
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  seq_state_t      state_q;
  logic [NREG-1:0] list_q;
  logic [AW-1:0]   addr_q, fin_q;
  logic            load_q, wbreq_q;
  logic            ld_valid_q, done_q, wb_valid_q, err_q;
  logic [IDXW-1:0] ld_idx_q;
  logic [DW-1:0]   ld_data_q;
  logic [AW-1:0]   wb_base_q;

  logic [NREG-1:0] scan_in;
  logic [CNTW-1:0] scan_cnt;
  logic [IDXW-1:0] scan_low;
  logic [AW-1:0]   start_addr, final_base;
  logic            accept, illegal, handshake, last_xfer;

  assign scan_in = (state_q == SQ_IDLE) ? cmd_list : list_q;

  blk_xfer_list_scan #(.NREG(NREG)) u_scan (
    .list(scan_in), .cnt(scan_cnt), .low_idx(scan_low)
  );

  blk_xfer_addr_gen #(.AW(AW), .CNTW(CNTW), .WORD_BYTES(WORD_BYTES)) u_addr (
    .base(cmd_base), .cnt(scan_cnt), .mode(addr_mode_t'(cmd_mode)),
    .start_addr(start_addr), .final_base(final_base)
  );

  assign cmd_ready = (state_q == SQ_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign illegal   = (scan_cnt == '0) || (cmd_wb && cmd_list[cmd_base_idx]);
  assign handshake = (state_q == SQ_XFER) && mem_ready;
  assign last_xfer = (scan_cnt == CNTW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SQ_IDLE;
      list_q     <= '0;
      addr_q     <= '0;
      fin_q      <= '0;
      load_q     <= 1'b0;
      wbreq_q    <= 1'b0;
      ld_valid_q <= 1'b0;
      ld_idx_q   <= '0;
      ld_data_q  <= '0;
      done_q     <= 1'b0;
      wb_valid_q <= 1'b0;
      wb_base_q  <= '0;
      err_q      <= 1'b0;
    end else begin
      ld_valid_q <= 1'b0;
      done_q     <= 1'b0;
      wb_valid_q <= 1'b0;
      err_q      <= 1'b0;
      if (accept) begin
        if (illegal) begin
          err_q <= 1'b1;
        end else begin
          state_q <= SQ_XFER;
          list_q  <= cmd_list;
          addr_q  <= start_addr;
          fin_q   <= final_base;
          load_q  <= cmd_load;
          wbreq_q <= cmd_wb;
        end
      end else if (handshake) begin
        list_q[scan_low] <= 1'b0;
        addr_q           <= addr_q + STEP;
        if (load_q) begin
          ld_valid_q <= 1'b1;
          ld_idx_q   <= scan_low;
          ld_data_q  <= mem_rdata;
        end
        if (last_xfer) begin
          state_q    <= SQ_IDLE;
          done_q     <= 1'b1;
          wb_valid_q <= wbreq_q;
          wb_base_q  <= fin_q;
        end
      end
    end
  end

  assign mem_req  = (state_q == SQ_XFER);
  assign mem_we   = !load_q;
  assign mem_addr = addr_q;
  assign mem_idx  = scan_low;
  assign ld_valid = ld_valid_q;
  assign ld_idx   = ld_idx_q;
  assign ld_data  = ld_data_q;
  assign done     = done_q;
  assign wb_valid = wb_valid_q;
  assign wb_base  = wb_base_q;
  assign err      = err_q;

  p_busy_blocks_cmd_r1: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cmd_ready);
  p_hold_until_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_idx) && $stable(mem_we)));
  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready && !last_xfer) |=> (mem_req && mem_addr == $past(mem_addr) + STEP));
  p_idx_ascend_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready && !last_xfer) |=> (mem_idx > $past(mem_idx)));
  p_last_gives_done_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready && last_xfer) |=> (done && cmd_ready));
  p_wb_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> done);
  p_err_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    err |-> (!mem_req && !done && !wb_valid && !ld_valid));
  p_store_no_load_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ready) |=> !ld_valid);
endmodule

// File: tb/blk_xfer_seq_tb_top.sv
module blk_xfer_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready, cmd_load = 1'b0, cmd_wb = 1'b0;
  logic [15:0] cmd_list = '0;
  logic [31:0] cmd_base = '0;
  logic [3:0]  cmd_base_idx = '0;
  logic [1:0]  cmd_mode = '0;
  logic        mem_req, mem_we, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_rdata;
  logic [3:0]  mem_idx, ld_idx;
  logic        ld_valid, done, wb_valid, err;
  logic [31:0] ld_data, wb_base;

  assign mem_rdata = mem_addr ^ 32'hC3C3_0000 ^ {28'd0, mem_idx};

  blk_xfer_seq dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_list(cmd_list), .cmd_base(cmd_base), .cmd_base_idx(cmd_base_idx),
    .cmd_load(cmd_load), .cmd_mode(cmd_mode), .cmd_wb(cmd_wb),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_idx(mem_idx),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
    .ld_idx(ld_idx), .ld_data(ld_data), .done(done), .wb_valid(wb_valid),
    .wb_base(wb_base), .err(err)
  );

  localparam int NCMD = 16;
  logic [15:0] c_list [NCMD];
  logic [31:0] c_base [NCMD];
  logic [3:0]  c_bidx [NCMD];
  logic        c_load [NCMD];
  logic [1:0]  c_mode [NCMD];
  logic        c_wb   [NCMD];
  logic [31:0] wb_log [NCMD];

  int checks = 0, fails = 0, cyc = 0, ptr = 0;

  // reference model state
  bit          m_busy = 0, m_load = 0, m_wb = 0;
  int          m_idq[$];
  logic [31:0] m_adq[$];
  logic [31:0] m_fin = '0;
  int          m_id = 0, m_done_id = 0;
  bit          m_ld_pend = 0, m_done_pend = 0, m_wb_pend = 0, m_err_pend = 0;
  int          m_ld_idx = 0;
  logic [31:0] m_ld_data = '0, m_wb_val = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic add(input int k, input logic [15:0] l, input logic [31:0] b, input logic [3:0] bi,
                     input logic ld, input logic [1:0] md, input logic w);
    c_list[k] = l; c_base[k] = b; c_bidx[k] = bi; c_load[k] = ld; c_mode[k] = md; c_wb[k] = w;
    wb_log[k] = 32'hDEAD_BEEF;
  endtask

  task automatic model_accept(input int k);
    int n;
    logic [31:0] lo;
    n = 0;
    for (int i = 0; i < 16; i++) if (c_list[k][i]) n++;
    if (n == 0 || (c_wb[k] && c_list[k][c_bidx[k]])) begin
      m_err_pend = 1;
      return;
    end
    case (c_mode[k])
      2'd0: lo = c_base[k];
      2'd1: lo = c_base[k] + 32'd4;
      2'd2: lo = c_base[k] - 32'(4 * n) + 32'd4;
      default: lo = c_base[k] - 32'(4 * n);
    endcase
    m_fin = (c_mode[k] < 2) ? c_base[k] + 32'(4 * n) : c_base[k] - 32'(4 * n);
    for (int i = 0; i < 16; i++) if (c_list[k][i]) begin
      m_idq.push_back(i);
      m_adq.push_back(lo);
      lo = lo + 32'd4;
    end
    m_busy = 1; m_load = c_load[k]; m_wb = c_wb[k]; m_id = k;
  endtask

  initial begin
    // modes: 0 IA, 1 IB, 2 DA, 3 DB
    add(0,  16'h000F, 32'h0000_1000, 4'd9,  1, 2'd0, 0);
    add(1,  16'h8001, 32'h0000_2000, 4'd5,  0, 2'd1, 1);
    add(2,  16'h1234, 32'h0000_3000, 4'd0,  1, 2'd2, 1);
    add(3,  16'hFFFF, 32'h0000_4000, 4'd0,  0, 2'd3, 0);
    add(4,  16'h0000, 32'h0000_5000, 4'd2,  1, 2'd0, 1);  // empty: illegal
    add(5,  16'h0021, 32'h0000_5000, 4'd5,  0, 2'd0, 1);  // base in list + wb: illegal
    add(6,  16'h0021, 32'h0000_6000, 4'd5,  1, 2'd1, 0);  // base in list, no wb: legal
    add(7,  16'h4000, 32'h0000_0010, 4'd1,  1, 2'd3, 1);
    add(8,  16'h00F0, 32'h0000_8000, 4'd13, 0, 2'd3, 1);  // full-desc push
    add(9,  16'h00F0, 32'h0000_7FF0, 4'd13, 1, 2'd0, 1);  // full-desc pop
    add(10, 16'h0C03, 32'h0000_9000, 4'd13, 0, 2'd1, 1);  // full-asc push
    add(11, 16'h0C03, 32'h0000_9010, 4'd13, 1, 2'd2, 1);  // full-asc pop
    add(12, 16'h0101, 32'h0000_A000, 4'd13, 0, 2'd2, 1);  // empty-desc push
    add(13, 16'h0101, 32'h0000_9FF8, 4'd13, 1, 2'd1, 1);  // empty-desc pop
    add(14, 16'h0006, 32'h0000_0000, 4'd13, 0, 2'd0, 1);  // empty-asc push
    add(15, 16'h0006, 32'h0000_0008, 4'd13, 1, 2'd3, 1);  // empty-asc pop

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 reset cmd_ready", 32'(cmd_ready), 32'd1);
    chk(mem_req == 1'b0, "R1 reset mem_req", 32'(mem_req), 32'd0);
    chk(done == 1'b0 && err == 1'b0 && wb_valid == 1'b0 && ld_valid == 1'b0,
        "R1 reset pulses", {done, err, wb_valid, ld_valid}, 32'd0);
    rst = 1'b0;

    forever begin
      // compare outputs with the model
      chk(cmd_ready == !m_busy, "R1 cmd_ready", 32'(cmd_ready), 32'(!m_busy));
      chk(mem_req == m_busy, "R7 mem_req", 32'(mem_req), 32'(m_busy));
      if (m_busy && mem_req) begin
        chk(mem_addr == m_adq[0], "R3 R4 mem_addr", mem_addr, m_adq[0]);
        chk(32'(mem_idx) == 32'(m_idq[0]), "R2 mem_idx", 32'(mem_idx), 32'(m_idq[0]));
        chk(mem_we == !m_load, "R8 mem_we", 32'(mem_we), 32'(!m_load));
      end
      chk(ld_valid == m_ld_pend, "R8 ld_valid", 32'(ld_valid), 32'(m_ld_pend));
      if (m_ld_pend && ld_valid) begin
        chk(32'(ld_idx) == 32'(m_ld_idx), "R8 ld_idx", 32'(ld_idx), 32'(m_ld_idx));
        chk(ld_data == m_ld_data, "R8 ld_data", ld_data, m_ld_data);
      end
      chk(done == m_done_pend, "R9 done", 32'(done), 32'(m_done_pend));
      chk(wb_valid == m_wb_pend, "R5 wb_valid", 32'(wb_valid), 32'(m_wb_pend));
      if (m_wb_pend && wb_valid) begin
        chk(wb_base == m_wb_val, "R5 wb_base", wb_base, m_wb_val);
        wb_log[m_done_id] = wb_base;
      end
      chk(err == m_err_pend, "R6 err", 32'(err), 32'(m_err_pend));

      if (ptr >= NCMD && !m_busy && !m_ld_pend && !m_done_pend && !m_err_pend) break;
      if (cyc > 20000) begin
        fails++; checks++;
        $display("FAIL R9 watchdog act=%0d exp=<20000", cyc);
        break;
      end

      // drive next inputs
      cyc++;
      cmd_valid = (ptr < NCMD) && ((cyc % 4) != 0);
      if (ptr < NCMD) begin
        cmd_list = c_list[ptr]; cmd_base = c_base[ptr]; cmd_base_idx = c_bidx[ptr];
        cmd_load = c_load[ptr]; cmd_mode = c_mode[ptr]; cmd_wb = c_wb[ptr];
      end
      mem_ready = ((cyc * 5 + ptr) % 7) > 2;

      // advance model over the coming edge
      m_ld_pend = 0; m_done_pend = 0; m_wb_pend = 0; m_err_pend = 0;
      if (m_busy) begin
        if (mem_ready) begin
          if (m_load) begin
            m_ld_pend = 1;
            m_ld_idx  = m_idq[0];
            m_ld_data = m_adq[0] ^ 32'hC3C3_0000 ^ 32'(m_idq[0]);
          end
          void'(m_idq.pop_front());
          void'(m_adq.pop_front());
          if (m_idq.size() == 0) begin
            m_busy = 0; m_done_pend = 1; m_wb_pend = m_wb;
            m_wb_val = m_fin; m_done_id = m_id;
          end
        end
      end else if (cmd_valid) begin
        model_accept(ptr);
        ptr++;
      end
      @(negedge clk);
    end

    // stack alias pairs: pop after push restores the base
    chk(wb_log[9]  == c_base[8],  "R10 full-desc pop",  wb_log[9],  c_base[8]);
    chk(wb_log[11] == c_base[10], "R10 full-asc pop",   wb_log[11], c_base[10]);
    chk(wb_log[13] == c_base[12], "R10 empty-desc pop", wb_log[13], c_base[12]);
    chk(wb_log[15] == c_base[14], "R10 empty-asc pop",  wb_log[15], c_base[14]);
    chk(wb_log[8]  == 32'h0000_7FF0, "R10 full-desc push", wb_log[8], 32'h0000_7FF0);
    chk(wb_log[4]  == 32'hDEAD_BEEF, "R6 no wb on illegal", wb_log[4], 32'hDEAD_BEEF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule